// File: doc/BRIEF.md
# SPI Memory Command Master

This block runs one complete SPI transaction against a serial EEPROM or flash part. A transaction is an 8-bit command, then an address of 0, 8, 16 or 24 bits, then a data phase of a chosen number of bytes. The host starts it with a one-cycle pulse that carries every setting for the transaction. The block then drives the serial clock, the outgoing data line and one chip select, and it samples the incoming data line. The data phase writes and reads at the same time. Bytes to send come in through a valid/ready handshake. Each received byte appears on an output together with a one-cycle strobe.

All settings are captured when the start pulse is accepted. These include the clock polarity, the clock phase and the select polarity. One option serves parts with a 9-bit address: it moves address bit 8 into the command byte and sends only one address byte. The serial clock runs at a fixed ratio. Each half period lasts `HALF_DIV` system clock cycles.

Top module: `spi_mem_master`

## Requirements
- R1: After reset `busy_o`, `tx_ready_o` and `rx_valid_o` are low. With `mode_i` zero, `cs_o` is high and `sclk_o` is low.
- R2: Every transaction starts with the 8-bit command byte, sent most significant bit first, before any address or data bit.
- R3: When `addr_en_i` is low there is no address phase. Otherwise the address is sent MSB first with a width set by `addr_len_i`: code 0 sends `addr_i[7:0]`, code 1 sends `addr_i[15:0]`, and codes 2 and 3 send `addr_i[23:0]`.
- R4: When `munge_i` and `addr_en_i` are both high, the command byte is sent with bit 3 ORed with `addr_i[8]`. Exactly one address byte, `addr_i[7:0]`, follows, whatever `addr_len_i` says.
- R5: `mode_i[0]` selects the clock phase. When it is 0, incoming data is sampled on the leading clock edge and outgoing data changes on the trailing edge. When it is 1, outgoing data changes on the leading edge and incoming data is sampled on the trailing edge.
- R6: `mode_i[1]` sets the idle level of `sclk_o`. The clock holds that level between transactions and before the first edge. The leading edge is the first transition away from that level.
- R7: `mode_i[4]` sets the select polarity. When it is 1, `cs_o` is high while selected. When it is 0, `cs_o` is low while selected. The select stays at its active level for the whole time `busy_o` is high.
- R8: The select becomes active in the cycle after the accepted start pulse, which is also when `busy_o` rises. The first clock edge comes `HALF_DIV` cycles after that. The select is released `HALF_DIV` cycles after the last edge, and `busy_o` falls together with it. With no stall, `busy_o` stays high for (2·N+1)·`HALF_DIV` cycles, where N is the number of bits sent. A start pulse that arrives while busy is ignored.
- R9: With `count_i` zero, the transaction ends right after the address phase, or right after the command when there is no address.
- R10: Each received data byte is assembled MSB first. It appears on `rx_data_o` with a one-cycle `rx_valid_o` strobe in the cycle after its eighth sample. There is exactly one strobe per data byte.
- R11: When `wr_en_i` is high, each data byte sent is taken through one `tx_valid_i`/`tx_ready_o` handshake. If a byte has not arrived when it is needed, the serial clock holds its level until it does. When `wr_en_i` is low, data bytes are sent as zeros and `tx_ready_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; taken only when idle |
| cmd_i | input | 8 | Command byte |
| addr_i | input | 24 | Address value |
| addr_en_i | input | 1 | Address phase present |
| addr_len_i | input | 2 | Address width code (0: 8, 1: 16, 2/3: 24 bits) |
| munge_i | input | 1 | Fold address bit 8 into command bit 3 |
| count_i | input | CNT_W | Number of data bytes |
| wr_en_i | input | 1 | Data bytes come from the transmit handshake |
| mode_i | input | 5 | Bit 0 clock phase, bit 1 clock polarity, bit 4 select polarity |
| busy_o | output | 1 | Transaction in progress |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Block can take a transmit byte |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_o | output | 1 | Chip select |
| miso_i | input | 1 | Serial data in |

## Verification
Transactions are run in all four clock modes. Because the slave model samples and shifts on the edges that each mode defines, a design that uses the wrong edge loses or shifts bits. The tests cover every address width as well as an absent address, so a frame with too many or too few address bytes fails the bit count. A munged address with bit 8 set distinguishes a correctly folded command from an unfolded one. Writes with a slow feeder are compared against writes with an eager one, which shows that the clock stalls rather than sending stale bytes. Inverted select polarity and a start pulse sent in the middle of a frame confirm that the select level is correct and that the frame is not disturbed.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int MODE_W     = 5;
    localparam int MODE_PHASE = 0;
    localparam int MODE_POL   = 1;
    localparam int MODE_SEL   = 4;
    localparam int ADDR_W     = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD
    } xfer_state_t;

    typedef enum logic [1:0] {
        BK_CMD,
        BK_ADDR,
        BK_DATA
    } byte_kind_t;

    typedef struct packed {
        logic phase;
        logic pol;
        logic sel_hi;
        logic wr;
    } link_cfg_t;

    function automatic logic [1:0] addr_bytes(input logic present,
                                              input logic fold,
                                              input logic [1:0] code);
        if (!present)
            return 2'd0;
        if (fold)
            return 2'd1;
        case (code)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [7:0] fold_cmd(input logic [7:0] c,
                                            input logic a8,
                                            input logic en);
        return en ? (c | {4'b0000, a8, 3'b000}) : c;
    endfunction

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a,
                                                     input logic [1:0] n);
        case (n)
            2'd1:    return {a[7:0], 16'h0000};
            2'd2:    return {a[15:0], 8'h00};
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hold,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= hold ? cnt : '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R11: a held tick stays asserted until released
    a_r11_hold_keeps_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && hold && run) |=> (tick || !run));

endmodule

// File: rtl/spi_tx_stage.sv
module spi_tx_stage #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             load_wr,
    input  logic             active,
    input  logic             take,
    input  logic [7:0]       tx_data_i,
    input  logic             tx_valid_i,
    output logic             tx_ready_o,
    output logic [7:0]       buf_data,
    output logic             buf_full
);
    logic [CNT_W-1:0] pending;
    logic             accept;

    assign tx_ready_o = active && !load && (pending != '0) && !buf_full;
    assign accept     = tx_ready_o && tx_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= '0;
            buf_data <= '0;
            buf_full <= 1'b0;
        end else if (load) begin
            pending  <= load_wr ? load_cnt : '0;
            buf_full <= 1'b0;
        end else begin
            if (accept) begin
                buf_data <= tx_data_i;
                buf_full <= 1'b1;
                pending  <= pending - 1'b1;
            end else if (take) begin
                buf_full <= 1'b0;
            end
        end
    end

    // R11: a byte is consumed only when one is staged
    a_r11_take_needs_data: assert property (@(posedge clk) disable iff (rst)
        take |-> buf_full);

    // R11: one handshake fills the single slot
    a_r11_one_per_slot: assert property (@(posedge clk) disable iff (rst)
        (tx_ready_o && tx_valid_i) |=> !tx_ready_o);

endmodule

// File: rtl/spi_rx_collect.sv
module spi_rx_collect (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample,
    input  logic       bit_in,
    input  logic       byte_end,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o
);
    logic [7:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= sample && byte_end;
            if (sample) begin
                shreg <= {shreg[6:0], bit_in};
                if (byte_end)
                    rx_data_o <= {shreg[6:0], bit_in};
            end
        end
    end

    // R10: every strobe follows a sampling edge
    a_r10_strobe_after_sample: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(sample));

endmodule

// File: rtl/spi_mem_master.sv
module spi_mem_master
    import spi_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [7:0]        cmd_i,
    input  logic [23:0]       addr_i,
    input  logic              addr_en_i,
    input  logic [1:0]        addr_len_i,
    input  logic              munge_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wr_en_i,
    input  logic [4:0]        mode_i,
    output logic              busy_o,
    input  logic [7:0]        tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [7:0]        rx_data_o,
    output logic              rx_valid_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_o,
    input  logic              miso_i
);
    localparam int UW = CNT_W + 2;

    xfer_state_t      st;
    byte_kind_t       kind;
    link_cfg_t        cfg;
    logic             sclk_lvl;
    logic [7:0]       sh;
    logic [2:0]       bit_idx;
    logic [UW-1:0]    units_left;
    logic [1:0]       addr_left;
    logic [ADDR_W-1:0] abuf;
    logic             fresh;

    logic       tick, run, accept_start;
    logic       adv_slot, byte_done, last_unit, need_data, stall;
    logic       tog, lead, trail, sample, finish, adv, take;
    logic [7:0] buf_data;
    logic       buf_full;
    logic [1:0] nab;

    assign run          = (st != ST_IDLE);
    assign accept_start = (st == ST_IDLE) && start_i;
    assign nab          = addr_bytes(addr_en_i, munge_i, addr_len_i);

    assign byte_done = (bit_idx == 3'd7);
    assign last_unit = (units_left == '0);
    assign need_data = byte_done && !last_unit && (addr_left == 2'd0);
    assign adv_slot  = (st == ST_RUN) &&
                       (cfg.phase ? (!sclk_lvl && !fresh) : sclk_lvl);
    assign stall     = adv_slot && need_data && cfg.wr && !buf_full;

    assign tog    = tick && (st == ST_RUN) && !stall;
    assign lead   = tog && !sclk_lvl;
    assign trail  = tog && sclk_lvl;
    assign sample = cfg.phase ? trail : lead;
    assign finish = trail && byte_done && last_unit;
    assign adv    = tog && adv_slot && !finish;
    assign take   = adv && need_data && cfg.wr;

    spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .hold (stall),
        .tick (tick)
    );

    spi_tx_stage #(.CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .load       (accept_start),
        .load_cnt   (count_i),
        .load_wr    (wr_en_i),
        .active     (run),
        .take       (take),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .buf_data   (buf_data),
        .buf_full   (buf_full)
    );

    spi_rx_collect u_rx (
        .clk        (clk),
        .rst        (rst),
        .sample     (sample),
        .bit_in     (miso_i),
        .byte_end   (byte_done && (kind == BK_DATA)),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            kind       <= BK_CMD;
            cfg        <= '0;
            sclk_lvl   <= 1'b0;
            sh         <= '0;
            bit_idx    <= '0;
            units_left <= '0;
            addr_left  <= '0;
            abuf       <= '0;
            fresh      <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        st         <= ST_RUN;
                        kind       <= BK_CMD;
                        cfg        <= '{phase:  mode_i[MODE_PHASE],
                                        pol:    mode_i[MODE_POL],
                                        sel_hi: mode_i[MODE_SEL],
                                        wr:     wr_en_i};
                        sclk_lvl   <= 1'b0;
                        sh         <= fold_cmd(cmd_i, addr_i[8], munge_i && addr_en_i);
                        bit_idx    <= '0;
                        units_left <= UW'(nab) + UW'(count_i);
                        addr_left  <= nab;
                        abuf       <= align_addr(addr_i, nab);
                        fresh      <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (tog) begin
                        sclk_lvl <= ~sclk_lvl;
                        fresh    <= 1'b0;
                        if (finish)
                            st <= ST_HOLD;
                    end
                    if (adv) begin
                        if (!byte_done) begin
                            sh      <= {sh[6:0], 1'b0};
                            bit_idx <= bit_idx + 3'd1;
                        end else begin
                            bit_idx    <= '0;
                            units_left <= units_left - 1'b1;
                            if (addr_left != 2'd0) begin
                                kind      <= BK_ADDR;
                                sh        <= abuf[ADDR_W-1 -: 8];
                                abuf      <= {abuf[ADDR_W-9:0], 8'h00};
                                addr_left <= addr_left - 2'd1;
                            end else begin
                                kind <= BK_DATA;
                                sh   <= cfg.wr ? buf_data : 8'h00;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick)
                        st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = run;
    assign mosi_o = sh[7];
    assign sclk_o = run ? (sclk_lvl ^ cfg.pol) : mode_i[MODE_POL];
    assign cs_o   = run ? cfg.sel_hi : ~mode_i[MODE_SEL];

    // R2: a frame opens on the first command bit
    a_r2_cmd_leads: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (kind == BK_CMD && bit_idx == 3'd0));

    // R9: the hold interval begins only when every byte is used up
    a_r9_hold_after_units: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (units_left == '0 && !sclk_lvl));

    // R7: select level does not move inside a frame
    a_r7_cs_steady: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(cs_o));

    // R11: a stalled slot leaves the serial clock level untouched
    a_r11_stall_freezes: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(sclk_lvl));

endmodule

// File: tb/tb_spi_mem_master.sv
module tb_spi_mem_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  cmd_i;
    logic [23:0] addr_i;
    logic        addr_en_i;
    logic [1:0]  addr_len_i;
    logic        munge_i;
    logic [7:0]  count_i;
    logic        wr_en_i;
    logic [4:0]  mode_i;
    logic        busy_o;
    logic [7:0]  tx_data_i;
    logic        tx_valid_i;
    logic        tx_ready_o;
    logic [7:0]  rx_data_o;
    logic        rx_valid_o;
    logic        sclk_o, mosi_o, cs_o, miso_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_master #(.HALF_DIV(HALF), .CNT_W(8)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
        .addr_en_i(addr_en_i), .addr_len_i(addr_len_i), .munge_i(munge_i),
        .count_i(count_i), .wr_en_i(wr_en_i), .mode_i(mode_i), .busy_o(busy_o),
        .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .cs_o(cs_o), .miso_i(miso_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // shared bench state
    bit         in_xfer = 0;
    logic       cur_pha, cur_pol, cur_sel;
    logic [7:0] cap [0:31];
    int         nbits;
    int         mi;
    logic [7:0] rxc [0:31];
    int         rx_n;
    logic [7:0] tx_q [0:31];
    int         tx_n, tx_i, tx_gap, gap_cnt;
    bit         hs;
    bit         rdy_seen;
    int         cyc = 0;
    int         t_cs, t_first, t_last, t_rel, busy_cnt, cs_cnt;
    bit         seen_cs, seen_edge, seen_rel;
    logic       sclk_prev, sclk_at_cs;

    function automatic logic [7:0] pat_byte(input int k);
        logic [7:0] v;
        v = 8'(k * 29 + 7);
        return v ^ 8'hA5;
    endfunction

    function automatic logic stream_bit(input int i);
        logic [7:0] b;
        b = pat_byte(i / 8);
        return b[7 - (i % 8)];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // serial slave model: capture on sample edges, drive on shift edges
    initial begin
        miso_i = 1'b0;
        forever begin
            @(sclk_o);
            if (in_xfer && (cs_o == cur_sel)) begin
                logic lead;
                lead = (sclk_o != cur_pol);
                if (lead ^ cur_pha) begin
                    if (nbits < 256)
                        cap[nbits / 8] = {cap[nbits / 8][6:0], mosi_o};
                    nbits++;
                end else begin
                    miso_i = stream_bit(mi);
                    mi++;
                end
            end
        end
    end

    always @(posedge clk) hs = tx_valid_i & tx_ready_o;

    // transmit feeder
    initial begin
        tx_valid_i = 1'b0;
        tx_data_i  = 8'h00;
        forever begin
            @(negedge clk);
            if (hs) begin
                tx_i++;
                tx_valid_i = 1'b0;
                gap_cnt = tx_gap;
            end
            if (!tx_valid_i && tx_i < tx_n) begin
                if (gap_cnt == 0) begin
                    tx_data_i  = tx_q[tx_i];
                    tx_valid_i = 1'b1;
                end else begin
                    gap_cnt--;
                end
            end
        end
    end

    // port monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (in_xfer) begin
                if (tx_ready_o) rdy_seen = 1;
                if (rx_valid_o && rx_n < 32) begin
                    rxc[rx_n] = rx_data_o;
                    rx_n++;
                end else if (rx_valid_o) begin
                    rx_n++;
                end
                if (busy_o) busy_cnt++;
                if (cs_o == cur_sel) begin
                    cs_cnt++;
                    if (!seen_cs) begin
                        seen_cs = 1; t_cs = cyc; sclk_at_cs = sclk_o;
                    end
                    if (sclk_o != sclk_prev) begin
                        if (!seen_edge) t_first = cyc;
                        seen_edge = 1;
                        t_last = cyc;
                    end
                end else if (seen_cs && !seen_rel) begin
                    seen_rel = 1; t_rel = cyc;
                end
            end
            sclk_prev = sclk_o;
        end
    end

    task automatic do_xfer(input string tag, input logic [7:0] c, input logic [23:0] a,
                           input logic ae, input logic [1:0] al, input logic mg,
                           input int cnt, input logic [4:0] md, input logic wr,
                           input int gap, input bit poke);
        int nab, nb, n_bits, wait_n;
        logic [7:0] expb [0:31];
        @(negedge clk);
        mode_i  = md;
        cur_pha = md[0]; cur_pol = md[1]; cur_sel = md[4];
        nab = !ae ? 0 : (mg ? 1 : (al == 2'd0 ? 1 : (al == 2'd1 ? 2 : 3)));
        nb = 1 + nab + cnt;
        n_bits = 8 * nb;
        expb[0] = (mg && ae) ? (c | {4'b0, a[8], 3'b0}) : c;
        for (int i = 0; i < nab; i++)
            expb[1 + i] = 8'(a >> (8 * (nab - 1 - i)));
        for (int j = 0; j < cnt; j++) begin
            tx_q[j] = 8'(8'h3C + j * 8'h47);
            expb[1 + nab + j] = wr ? tx_q[j] : 8'h00;
        end
        for (int i = 0; i < 32; i++) cap[i] = 8'h00;
        nbits = 0; rx_n = 0; rdy_seen = 0;
        busy_cnt = 0; cs_cnt = 0; seen_cs = 0; seen_edge = 0; seen_rel = 0;
        t_cs = 0; t_first = 0; t_last = 0; t_rel = 0;
        tx_i = 0; tx_gap = gap; gap_cnt = gap; tx_n = wr ? cnt : 0;
        if (!md[0]) begin miso_i = stream_bit(0); mi = 1; end
        else mi = 0;
        repeat (2) @(negedge clk);
        in_xfer = 1;
        cmd_i = c; addr_i = a; addr_en_i = ae; addr_len_i = al; munge_i = mg;
        count_i = 8'(cnt); wr_en_i = wr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8", {tag, " busy after start"}, busy_o, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            cmd_i = 8'hEE; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_n = 0;
        while (busy_o && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        repeat (2) @(negedge clk);
        in_xfer = 0;
        chk(!busy_o, "R8", {tag, " transaction ends"}, busy_o, 0);
        chk(nbits == n_bits, tag, "bit count on the line", nbits, n_bits);
        for (int i = 0; i < nb && i < 32; i++)
            chk(cap[i] == expb[i], tag, $sformatf("line byte %0d", i), cap[i], expb[i]);
        chk(rx_n == cnt, "R10", {tag, " rx strobe count"}, rx_n, cnt);
        for (int j = 0; j < cnt && j < rx_n && j < 32; j++)
            chk(rxc[j] == pat_byte(1 + nab + j), "R10", $sformatf("%s rx byte %0d", tag, j),
                rxc[j], pat_byte(1 + nab + j));
        chk(t_first - t_cs == HALF, "R8", {tag, " select setup"}, t_first - t_cs, HALF);
        chk(t_rel - t_last == HALF, "R8", {tag, " select hold"}, t_rel - t_last, HALF);
        chk(cs_cnt == busy_cnt, "R7", {tag, " select spans busy"}, cs_cnt, busy_cnt);
        chk(sclk_at_cs == md[1], "R6", {tag, " clock idle before first edge"}, sclk_at_cs, md[1]);
        chk(sclk_o == md[1], "R6", {tag, " clock idle after"}, sclk_o, md[1]);
        chk(cs_o == !md[4], "R7", {tag, " select released level"}, cs_o, !md[4]);
        if (gap == 0)
            chk(busy_cnt == (2 * n_bits + 1) * HALF, "R8", {tag, " busy length"},
                busy_cnt, (2 * n_bits + 1) * HALF);
        chk(tx_i == (wr ? cnt : 0), "R11", {tag, " handshakes"}, tx_i, wr ? cnt : 0);
        if (!wr)
            chk(!rdy_seen, "R11", {tag, " ready stays low"}, rdy_seen, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!busy_o, "R1", "busy at reset", busy_o, 0);
        chk(cs_o == 1'b1, "R1", "select at reset", cs_o, 1);
        chk(sclk_o == 1'b0, "R1", "clock at reset", sclk_o, 0);
        chk(!tx_ready_o, "R1", "tx ready at reset", tx_ready_o, 0);
        chk(!rx_valid_o, "R1", "rx strobe at reset", rx_valid_o, 0);
    endtask

    task automatic t_cmd_only;      // R2 R9
        do_xfer("R2", 8'h05, 24'h0, 1'b0, 2'd0, 1'b0, 0, 5'h00, 1'b0, 0, 0);
    endtask

    task automatic t_addr_widths;   // R3 R5 R6 R10
        do_xfer("R3", 8'h03, 24'h0000C7, 1'b1, 2'd0, 1'b0, 2, 5'h01, 1'b0, 0, 0);
        do_xfer("R5", 8'h0B, 24'h00B2E1, 1'b1, 2'd1, 1'b0, 3, 5'h02, 1'b0, 0, 0);
        do_xfer("R6", 8'h3B, 24'h5A0F96, 1'b1, 2'd2, 1'b0, 1, 5'h03, 1'b0, 0, 0);
    endtask

    task automatic t_munge;         // R4
        do_xfer("R4", 8'h03, 24'h0001A5, 1'b1, 2'd2, 1'b1, 2, 5'h00, 1'b0, 0, 0);
    endtask

    task automatic t_select_pol;    // R7
        do_xfer("R7", 8'h9F, 24'h0, 1'b0, 2'd0, 1'b0, 3, 5'h10, 1'b0, 0, 0);
    endtask

    task automatic t_writes;        // R11
        do_xfer("R11", 8'h02, 24'h001234, 1'b1, 2'd1, 1'b0, 3, 5'h03, 1'b1, 0, 0);
        do_xfer("R11", 8'h02, 24'h004321, 1'b1, 2'd1, 1'b0, 4, 5'h00, 1'b1, 80, 0);
        do_xfer("R11", 8'h03, 24'h0, 1'b0, 2'd0, 1'b0, 2, 5'h01, 1'b0, 0, 0);
    endtask

    task automatic t_restart_ignored; // R8
        do_xfer("R8", 8'h06, 24'h00ABCD, 1'b1, 2'd1, 1'b0, 1, 5'h02, 1'b0, 0, 1);
    endtask

    task automatic t_zero_count;    // R9
        do_xfer("R9", 8'hD8, 24'h123456, 1'b1, 2'd3, 1'b0, 0, 5'h01, 1'b0, 0, 0);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; cmd_i = '0; addr_i = '0; addr_en_i = 1'b0;
        addr_len_i = '0; munge_i = 1'b0; count_i = '0; wr_en_i = 1'b0; mode_i = '0;
        cur_pha = 0; cur_pol = 0; cur_sel = 0; sclk_prev = 0; sclk_at_cs = 0;
        nbits = 0; mi = 0; rx_n = 0; tx_n = 0; tx_i = 0; tx_gap = 0; gap_cnt = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cmd_only();
        t_addr_widths();
        t_munge();
        t_select_pol();
        t_writes();
        t_restart_ignored();
        t_zero_count();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule